// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a clocked request port to an external asynchronous 8K x 8 static RAM. The RAM has one active-low chip select, one active-high chip select, an active-low output enable, an active-low write enable and a shared bidirectional 8-bit data bus. A single read or write request carries a 13-bit address and, for writes, one data byte. The block then drives the memory strobes for a fixed number of system clocks. These counts are worked out when the design is built from the memory's minimum timings and a clock-period parameter, each converted with ceiling rounding.

The request port uses a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle and standby is not requested. A requester that sees `req_ready` low must hold its request, with the address and data stable, until it is taken. Completion is reported by a one-cycle `done` pulse. Read data appears on `rd_data` with that pulse and stays unchanged until the next read completes.

Holding `standby` high while idle parks the memory with both chip selects inactive. When `standby` drops, a recovery interval of one read-cycle time passes before a new request is taken.

Top module: `sram_async_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, both selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `done`=0 and `rd_data`=0. `req_ready` is 1 once reset is released with `standby` low.
- R2: A request is taken only on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the edge that takes a request until the sequencer returns to idle. `req_write`=1 selects a write and 0 selects a read.
- R3: A read holds `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly 9 cycles (80 ns ceiling-rounded at 10 ns, plus one margin cycle), starting with the cycle after acceptance. `mem_addr` equals the request address throughout.
- R4: `rd_data` takes the byte on the bus at the edge that ends the last read cycle. `done` is high for exactly the one following cycle. `rd_data` does not change at any other time, including during writes.
- R5: A write holds both selects active for 8 cycles with `mem_oe_n`=1 throughout. `mem_we_n` is 0 for the first 7 of those cycles and 1 in the eighth. `done` pulses in the cycle after the eighth.
- R6: During a write, the sequencer drives `mem_dq` with the request byte only in write-strobe cycles 4 to 7 (after a 3-cycle release window). That byte is what the memory stores when `mem_we_n` rises.
- R7: After a read, 2 bus-turnaround cycles follow with every strobe inactive and `req_ready`=0 before the next request can be taken.
- R8: `standby`=1 while idle forces `req_ready`=0 and keeps both selects inactive. The first edge that sees `standby`=0 starts an 8-cycle recovery, and `req_ready` returns after it. `standby` raised during an access has no effect until that access ends.
- R9: The sequencer never drives `mem_dq` while `mem_oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Request low-power parking of the memory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Memory address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 13 | Address to memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The bench runs isolated writes and reads at the lowest, highest and a mid address, and a read of a location never written. These show whether the strobe windows, the capture edge and the address path line up. Back-to-back requests, with `req_valid` held high, test the handshake and the turnaround gap that separates a read from the next access. A write placed between two reads shows that `rd_data` holds its value. Standby raised while idle, with a request already waiting, checks the recovery count. Standby raised in the middle of a write shows that the request is ignored until that access ends.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_TURN, ST_PARK, ST_WAKE
  } seq_state_t;

  function automatic int ceil_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CW      = 4,
  parameter int RD_CYC  = 9,
  parameter int WR_CYC  = 8,
  parameter int TA_CYC  = 2,
  parameter int RC_CYC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          take,
  output seq_state_t    state,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          capture
);

  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] TA_LAST = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] RC_LAST = CW'(RC_CYC - 1);

  assign req_ready = (state == ST_IDLE) && !standby;
  assign take      = req_ready && req_valid;
  assign capture   = (state == ST_READ) && (cnt == RD_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (standby)  state <= ST_PARK;
          else if (take) state <= req_write ? ST_WRITE : ST_READ;
        end
        ST_READ: begin
          if (cnt == RD_LAST) begin
            state <= ST_TURN;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_WRITE: begin
          if (cnt == WR_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_TURN: begin
          if (cnt == TA_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_PARK: begin
          cnt <= '0;
          if (!standby) state <= ST_WAKE;
        end
        ST_WAKE: begin
          if (cnt == RC_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_park_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !req_ready);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (state == ST_READ || state == ST_WRITE));
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
  import sram_seq_pkg::*;
#(
  parameter int CW     = 4,
  parameter int WZ_CYC = 3,
  parameter int WP_CYC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state,
  input  logic [CW-1:0] cnt,
  output logic          cs_n,
  output logic          cs,
  output logic          oe_n,
  output logic          we_n,
  output logic          drv_en
);

  localparam logic [CW-1:0] WZ_C = CW'(WZ_CYC);
  localparam logic [CW-1:0] WP_C = CW'(WP_CYC);

  logic active;

  always_comb begin
    active = (state == ST_READ) || (state == ST_WRITE);
    cs_n   = !active;
    cs     = active;
    oe_n   = (state != ST_READ);
    we_n   = !((state == ST_WRITE) && (cnt < WP_C));
    drv_en = (state == ST_WRITE) && (cnt >= WZ_C) && (cnt < WP_C);
  end

  assert_we_oe_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_drive_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!we_n && !cs_n));
  assert_we_rises_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !cs_n) |=> cs_n);

endmodule

// File: rtl/sram_data_port.sv
module sram_data_port #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          drv_en,
  input  logic          capture,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] rd_data,
  inout  wire  [DW-1:0] dq
);

  logic [DW-1:0] wdata_q;

  assign dq = drv_en ? wdata_q : {DW{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      if (take) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rd_data <= dq;
    end
  end

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_data));

endmodule

// File: rtl/sram_async_seq.sv
module sram_async_seq
  import sram_seq_pkg::*;
#(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 80,
  parameter int T_AA   = 80,
  parameter int T_ACE  = 80,
  parameter int T_OE   = 40,
  parameter int T_WC   = 80,
  parameter int T_WP   = 60,
  parameter int T_AW   = 70,
  parameter int T_DW   = 40,
  parameter int T_WZ   = 30,
  parameter int T_OHZ  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int RD_CYC = ceil_cyc(imax(imax(T_RC, T_AA), imax(T_ACE, T_OE)), CLK_NS) + 1;
  localparam int WZ_CYC = ceil_cyc(T_WZ, CLK_NS);
  localparam int WP_CYC = imax(imax(ceil_cyc(T_WP, CLK_NS), ceil_cyc(T_AW, CLK_NS)),
                               WZ_CYC + ceil_cyc(T_DW, CLK_NS));
  localparam int WR_CYC = imax(ceil_cyc(T_WC, CLK_NS), WP_CYC + 1);
  localparam int TA_CYC = imax(ceil_cyc(T_OHZ, CLK_NS), 1);
  localparam int RC_CYC = imax(ceil_cyc(T_RC, CLK_NS), 1);
  localparam int CW     = $clog2(imax(imax(RD_CYC, WR_CYC), imax(TA_CYC, RC_CYC)) + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          take;
  logic          capture;
  logic          drv_en;

  sram_seq_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC), .RC_CYC(RC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .standby(standby), .req_valid(req_valid),
    .req_write(req_write), .req_ready(req_ready), .take(take), .state(state),
    .cnt(cnt), .done(done), .capture(capture)
  );

  sram_strobe_dec #(
    .CW(CW), .WZ_CYC(WZ_CYC), .WP_CYC(WP_CYC)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt),
    .cs_n(mem_cs_n), .cs(mem_cs), .oe_n(mem_oe_n), .we_n(mem_we_n), .drv_en(drv_en)
  );

  sram_data_port #(
    .AW(AW), .DW(DW)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .take(take), .req_addr(req_addr),
    .req_wdata(req_wdata), .drv_en(drv_en), .capture(capture),
    .addr_q(mem_addr), .rd_data(rd_data), .dq(mem_dq)
  );

  assert_no_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> mem_oe_n);
  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  assert_idle_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n));

endmodule

// File: tb/test_sram_async_seq.sv
module test_sram_async_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rd_data;
  logic [12:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
  wire  [7:0]  mem_dq;

  always #5 clk = ~clk;

  sram_async_seq i_sram_async_seq (
    .clk(clk), .rst_n(rst_n), .standby(standby), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  // Behavioural memory on the pins
  logic [7:0]  mem [int];
  logic [7:0]  mdata = 8'hA5;
  logic        pend = 1'b0;
  logic [12:0] paddr = '0;
  logic [7:0]  pdat = '0;
  logic        mdrv;
  assign mdrv   = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
  assign mem_dq = mdrv ? mdata : 8'bz;

  always @(posedge clk) begin
    if (!mem_cs_n && mem_cs && !mem_we_n) begin
      pend  = 1'b1;
      paddr = mem_addr;
      pdat  = mem_dq;
    end else if (pend) begin
      mem[int'(paddr)] = pdat;
      pend = 1'b0;
    end
    mdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hA5;
  end

  // Cycle reference model: 0 idle, 1 read, 2 write, 3 turnaround, 4 parked, 5 waking
  logic [7:0]  gold [int];
  int          ph = 0, k = 0;
  logic [12:0] eaddr = '0;
  logic [7:0]  ewd = '0, erd = '0;
  bit          edone = 0, ewrdone = 0;

  always @(posedge clk) begin
    edone = 0; ewrdone = 0;
    if (!rst_n) begin
      ph = 0; k = 0; erd = '0;
    end else begin
      case (ph)
        0: if (standby) ph = 4;
           else if (req_valid) begin
             ph = req_write ? 2 : 1; k = 0; eaddr = req_addr; ewd = req_wdata;
           end
        1: if (k == 8) begin
             erd = gold.exists(int'(eaddr)) ? gold[int'(eaddr)] : 8'hA5;
             edone = 1; ph = 3; k = 0;
           end else k++;
        2: if (k == 7) begin
             gold[int'(eaddr)] = ewd; edone = 1; ewrdone = 1; ph = 0; k = 0;
           end else k++;
        3: if (k == 1) begin ph = 0; k = 0; end else k++;
        4: if (!standby) begin ph = 5; k = 0; end
        5: if (k == 7) begin ph = 0; k = 0; end else k++;
        default: ph = 0;
      endcase
    end
  end

  int total = 0, bad = 0, cyc = 0;
  bit run_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n, "R1 strobes in reset",
          {mem_cs_n, mem_cs, mem_oe_n, mem_we_n}, 4'b1011);
      chk(!done && rd_data == 8'h00, "R1 done/rd_data in reset", {done, rd_data}, 0);
    end else if (!run_done) begin
      bit esel, eoe, ewe, edrv;
      esel = (ph == 1) || (ph == 2);
      eoe  = (ph == 1);
      ewe  = (ph == 2) && (k < 7);
      edrv = (ph == 2) && (k >= 3) && (k < 7);
      chk(req_ready == (ph == 0 && !standby),
          (ph == 4 || ph == 5) ? "R8 ready in standby" : (ph == 3 ? "R7 ready in turnaround" : "R2 ready"),
          req_ready, (ph == 0 && !standby));
      chk(mem_cs_n == !esel && mem_cs == esel,
          ph == 1 ? "R3 read selects" : (ph == 2 ? "R5 write selects" : "R8 selects parked"),
          {mem_cs_n, mem_cs}, {!esel, esel});
      chk(mem_oe_n == !eoe, ph == 3 ? "R7 oe in turnaround" : "R3 output enable", mem_oe_n, !eoe);
      chk(mem_we_n == !ewe, "R5 write strobe", mem_we_n, !ewe);
      if (esel) chk(mem_addr == eaddr, "R3 address", mem_addr, eaddr);
      if (edrv) chk(mem_dq == ewd, "R6 write data on bus", mem_dq, ewd);
      if (eoe)  chk(!mem_oe_n && mem_dq == mdata, "R9 bus free during read", mem_dq, mdata);
      chk(done == edone, "R4 done pulse", done, edone);
      chk(rd_data == erd, "R4 read data", rd_data, erd);
      if (ewrdone)
        chk(mem.exists(int'(eaddr)) && mem[int'(eaddr)] == ewd, "R6 byte stored",
            mem.exists(int'(eaddr)) ? mem[int'(eaddr)] : -1, ewd);
    end
  end

  task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    // isolated writes at the edges and middle of the address range
    issue(1, 13'h0000, 8'h3C); settle();
    issue(1, 13'h1FFF, 8'hC3); settle();
    issue(1, 13'h0155, 8'h5A); settle();
    // isolated reads, including a never-written location
    issue(0, 13'h0000, 8'h00); settle();
    issue(0, 13'h1FFF, 8'h00); settle();
    issue(0, 13'h0AAA, 8'h00); settle();
    // back-to-back: read, write, read (rd_data must hold across the write)
    issue(0, 13'h0155, 8'h00);
    issue(1, 13'h0155, 8'h99);
    issue(0, 13'h1FFF, 8'h00);
    issue(0, 13'h0155, 8'h00);
    settle();
    // standby while idle with a request waiting
    standby = 1'b1;
    repeat (5) @(negedge clk);
    fork
      begin repeat (3) @(negedge clk); standby = 1'b0; end
      issue(0, 13'h0000, 8'h00);
    join
    settle();
    // standby raised during a write is deferred
    fork
      issue(1, 13'h0777, 8'hE1);
      begin repeat (3) @(negedge clk); standby = 1'b1; repeat (15) @(negedge clk); standby = 1'b0; end
    join
    settle();
    issue(0, 13'h0777, 8'h00);
    settle();
    run_done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule